// File: doc/BRIEF.md
# Frame-Synchronous Control Register Slave

This block is the software-facing register file of a streaming video engine. A 32-bit memory-mapped slave port with per-byte write enables lets software change run-time settings (output width, two edge-adaptive mode enables, coefficient bank choice and filter coefficients) at any moment. The engine never sees those live values directly. When it asks to begin a frame, the block decides whether the frame may start and, in the same cycle, copies the settings into shadow registers that stay fixed until the next accepted start.

The run/stop bit is sampled only at that per-frame decision point. Clearing it while a frame is running lets the frame finish. Only the next start request is refused. A busy flag covers the span from acceptance to the frame-end pulse. Two coefficient banks let software reload one bank while the engine reads the other. While a frame is in flight, writes aimed at the bank latched for that frame are dropped.

Top module: `vid_ctrl_regs`

## Requirements
- R1: After reset, the control, width and bank-select registers, all coefficients, every shadow output, `frame_busy` and `rd_data` are 0.
- R2: Byte lane k of `wdata` (bits 8k+7:8k) is written only when `byte_en[k]` is 1. This applies to the width register (address 3, WIDTH_W bits, zero-extended on read) and to the coefficient words. Lanes whose enable is 0 keep their old value.
- R3: Address 0 is control. Bit 0 is Go, bit 1 enables edge-adaptive coefficient selection and bit 2 enables edge-adaptive sharpening. All three are written through lane 0. They read back at the same positions, and the other bits read 0.
- R4: `frame_accept` is 1 exactly in a cycle where `frame_start_req` is 1, Go is 1 and `frame_busy` is 0. `frame_busy` is 1 from the next cycle on.
- R5: Clearing Go during a frame does not end that frame. A later start request with Go at 0 is not accepted, and `frame_busy` stays 0.
- R6: `frame_busy` falls in the cycle after a `frame_end` pulse seen while busy, and does not change otherwise except by R4. Status (address 1) bit 0 reads `frame_busy`.
- R7: Address 2 always reads 0, and writes to it change nothing.
- R8: `sh_edge_sel`, `sh_sharpen`, `sh_width` and `sh_bank` take the live control, width and bank-select values in the cycle of an accepted start. They change at no other time.
- R9: Address 4 bit 0 selects the coefficient bank. Coefficient word i of bank b is at address 16 + 8*b + i. While `frame_busy` is 1, a write to the bank equal to `sh_bank` is dropped. Writes to the other bank, and all writes while idle, take effect.
- R10: A read returns the live register contents on `rd_data` one cycle after `rd_en`, not the shadow copies. Unmapped addresses read 0.
- R11: `coef_rd_data` shows word `coef_rd_idx` of bank `sh_bank` one cycle after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | IDX_W+2 | Word address |
| wdata | input | 32 | Write data |
| byte_en | input | 4 | Per-lane write enables |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| frame_start_req | input | 1 | Engine asks to begin a frame |
| frame_end | input | 1 | Engine reports the frame finished |
| frame_accept | output | 1 | Start request granted this cycle |
| frame_busy | output | 1 | Frame in progress |
| sh_edge_sel | output | 1 | Shadow edge-adaptive selection enable |
| sh_sharpen | output | 1 | Shadow edge-adaptive sharpening enable |
| sh_width | output | WIDTH_W | Shadow output width in pixels |
| sh_bank | output | 1 | Shadow coefficient bank |
| coef_rd_idx | input | IDX_W | Engine coefficient index |
| coef_rd_data | output | 32 | Coefficient from the shadow bank |

## Verification
The assertions assume the engine gives `frame_end` only while `frame_busy` is 1. They also assume a start request may arrive at any time, because acceptance alone gates it. They further assume reads and writes never strobe in the same cycle. The stimulus drives every strobe from negative-edge tasks that issue one operation at a time. It raises `frame_end` only after a start has been seen accepted, and it sends start requests both while busy and with Go cleared, to exercise refusal.

// File: rtl/vid_ctrl_regs.sv
module vid_ctrl_regs #(
  parameter int IDX_W   = 3,
  parameter int WIDTH_W = 16,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic [3:0]         byte_en,
  output logic [31:0]        rd_data,
  input  logic               frame_start_req,
  input  logic               frame_end,
  output logic               frame_accept,
  output logic               frame_busy,
  output logic               sh_edge_sel,
  output logic               sh_sharpen,
  output logic [WIDTH_W-1:0] sh_width,
  output logic               sh_bank,
  input  logic [IDX_W-1:0]   coef_rd_idx,
  output logic [31:0]        coef_rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [2:0]         ctrl_q;
  logic [WIDTH_W-1:0] width_q;
  logic               bank_q;
  logic [31:0]        coef_mem [2*DEPTH];

  logic             is_coef, coef_bank, coef_blocked;
  logic [IDX_W-1:0] coef_idx;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    return r;
  endfunction

  assign is_coef      = addr[ADDR_W-1];
  assign coef_bank    = addr[ADDR_W-2];
  assign coef_idx     = addr[IDX_W-1:0];
  assign coef_blocked = frame_busy && (coef_bank == sh_bank);
  assign frame_accept = frame_start_req && ctrl_q[0] && !frame_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      width_q <= '0;
      bank_q  <= 1'b0;
    end else if (wr_en && !is_coef) begin
      if (addr == ADDR_W'(0) && byte_en[0]) ctrl_q <= wdata[2:0];
      if (addr == ADDR_W'(3))
        width_q <= WIDTH_W'(lane_merge(32'(width_q), wdata, byte_en));
      if (addr == ADDR_W'(4) && byte_en[0]) bank_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*DEPTH; i++) coef_mem[i] <= '0;
    end else if (wr_en && is_coef && !coef_blocked) begin
      coef_mem[{coef_bank, coef_idx}] <=
        lane_merge(coef_mem[{coef_bank, coef_idx}], wdata, byte_en);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_busy  <= 1'b0;
      sh_edge_sel <= 1'b0;
      sh_sharpen  <= 1'b0;
      sh_width    <= '0;
      sh_bank     <= 1'b0;
    end else if (frame_accept) begin
      frame_busy  <= 1'b1;
      sh_edge_sel <= ctrl_q[1];
      sh_sharpen  <= ctrl_q[2];
      sh_width    <= width_q;
      sh_bank     <= bank_q;
    end else if (frame_busy && frame_end) begin
      frame_busy  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (is_coef) rd_data <= coef_mem[{coef_bank, coef_idx}];
      else begin
        case (addr)
          ADDR_W'(0): rd_data <= {29'd0, ctrl_q};
          ADDR_W'(1): rd_data <= {31'd0, frame_busy};
          ADDR_W'(3): rd_data <= 32'(width_q);
          ADDR_W'(4): rd_data <= {31'd0, bank_q};
          default:    rd_data <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) coef_rd_data <= '0;
    else        coef_rd_data <= coef_mem[{sh_bank, coef_rd_idx}];
  end
endmodule

// File: rtl/vid_ctrl_regs_chk.sv
module vid_ctrl_regs_chk #(
  parameter int IDX_W   = 3,
  parameter int WIDTH_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               wr_en,
  input logic [IDX_W+1:0]   addr,
  input logic [31:0]        rd_data,
  input logic               frame_end,
  input logic               frame_accept,
  input logic               frame_busy,
  input logic               sh_edge_sel,
  input logic               sh_sharpen,
  input logic [WIDTH_W-1:0] sh_width,
  input logic               sh_bank
);
  // R4
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> !frame_busy);
  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> frame_busy);
  // R6
  end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy && frame_end |=> !frame_busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy && !frame_end |=> frame_busy);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_busy && !frame_accept |=> !frame_busy);
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_accept |=> $stable({sh_edge_sel, sh_sharpen, sh_width, sh_bank}));
  // R7
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == (IDX_W+2)'(2) |=> rd_data == 32'd0);
endmodule

bind vid_ctrl_regs vid_ctrl_regs_chk #(.IDX_W(IDX_W), .WIDTH_W(WIDTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .frame_end(frame_end), .frame_accept(frame_accept),
  .frame_busy(frame_busy), .sh_edge_sel(sh_edge_sel), .sh_sharpen(sh_sharpen),
  .sh_width(sh_width), .sh_bank(sh_bank)
);

// File: tb/sim_vid_ctrl_regs.sv
`timescale 1ns/1ps
module sim_vid_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] byte_en = '0;
  logic [31:0] rd_data, coef_rd_data;
  logic frame_start_req = 0, frame_end = 0, frame_accept, frame_busy;
  logic sh_edge_sel, sh_sharpen, sh_bank;
  logic [15:0] sh_width;
  logic [2:0] coef_rd_idx = '0;

  int n_run = 0, n_fail = 0;
  logic [31:0] mdl [16];
  logic [15:0] w_mdl;

  always #2.5 clk = ~clk;

  vid_ctrl_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    addr = a; wdata = d; byte_en = be; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    @(negedge clk);
    d = rd_data; rd_en = 0;
  endtask

  task automatic start(output logic acc);
    frame_start_req = 1;
    #1 acc = frame_accept;
    @(negedge clk);
    frame_start_req = 0;
  endtask

  task automatic finish_frame;
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic acc;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 5; a++) begin rd(5'(a), d); chk("R1 reg", d, 0); end
    for (int a = 16; a < 32; a++) begin rd(5'(a), d); chk("R1 coef", d, 0); end
    chk("R1 shadow", {sh_edge_sel, sh_sharpen, sh_bank, 16'(sh_width), frame_busy}, 0);

    // R2 byte-lane sweep on width register
    w_mdl = '0;
    for (int be = 0; be < 16; be++) begin
      logic [31:0] v;
      v = {8'(be*7+3), 8'(be*11+5), 8'(be*13+1), 8'(be*17+9)};
      wr(5'd3, v, 4'(be));
      w_mdl = 16'(merge(32'(w_mdl), v, 4'(be)));
      rd(5'd3, d);
      chk("R2 width lanes", d, 32'(w_mdl));
    end

    // R3 control bits, all patterns, lane 0 gating
    for (int c = 0; c < 8; c++) begin
      wr(5'd0, 32'hFFFF_FFF8 | 32'(c), 4'b0001);
      rd(5'd0, d);
      chk("R3 ctrl", d, 32'(c));
    end
    wr(5'd0, 32'h0, 4'b1110);
    rd(5'd0, d); chk("R3 ctrl lane0 only", d, 32'd7);

    // R7 interrupt address
    wr(5'd2, 32'hFFFF_FFFF, 4'hF);
    rd(5'd2, d); chk("R7 irq", d, 0);
    rd(5'd0, d); chk("R7 no side effect", d, 32'd7);
    rd(5'd15, d); chk("R10 unmapped", d, 0);

    // R4 / R8 shadow load
    wr(5'd3, 32'd1920, 4'hF);
    wr(5'd4, 32'd1, 4'hF);
    wr(5'd0, 32'd7, 4'hF);
    chk("R6 idle", frame_busy, 0);
    start(acc);
    chk("R4 accept", acc, 1);
    chk("R4 busy", frame_busy, 1);
    chk("R8 load", {sh_edge_sel, sh_sharpen, sh_bank, sh_width}, {3'b111, 16'd1920});
    rd(5'd1, d); chk("R6 status busy", d, 1);
    start(acc); chk("R4 refused while busy", acc, 0);
    wr(5'd3, 32'd640, 4'hF);
    wr(5'd4, 32'd0, 4'hF);
    wr(5'd0, 32'd1, 4'hF);
    chk("R8 hold", {sh_edge_sel, sh_sharpen, sh_bank, sh_width}, {3'b111, 16'd1920});
    rd(5'd3, d); chk("R10 live width", d, 32'd640);
    rd(5'd0, d); chk("R10 live ctrl", d, 32'd1);
    finish_frame;
    chk("R6 end", frame_busy, 0);
    rd(5'd1, d); chk("R6 status idle", d, 0);
    start(acc);
    chk("R8 reload", {acc, sh_edge_sel, sh_sharpen, sh_bank, sh_width}, {4'b1000, 16'd640});

    // R5 stop takes effect at next start
    wr(5'd0, 32'd0, 4'hF);
    repeat (3) @(negedge clk);
    chk("R5 keeps running", frame_busy, 1);
    finish_frame;
    start(acc);
    chk("R5 refused", acc, 0);
    chk("R5 stays idle", frame_busy, 0);

    // R9 / R11 bank protection sweep
    for (int lb = 0; lb < 2; lb++) begin
      wr(5'd4, 32'(lb), 4'h1);
      wr(5'd0, 32'd1, 4'h1);
      start(acc);
      chk("R9 frame start", {acc, sh_bank}, {1'b1, 1'(lb)});
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 8; i++) begin
          logic [31:0] v;
          v = 32'h1000_0000 * (lb + 1) + 32'(b * 256 + i * 17 + 5);
          wr(5'(16 + 8*b + i), v, 4'hF);
          if (b != lb) mdl[8*b + i] = v;
        end
      for (int i = 0; i < 8; i++) begin
        coef_rd_idx = 3'(i);
        @(negedge clk);
        chk("R11 engine port", coef_rd_data, mdl[8*lb + i]);
      end
      finish_frame;
      for (int a = 0; a < 16; a++) begin
        rd(5'(16 + a), d);
        chk("R9 busy writes", d, mdl[a]);
      end
    end
    // R9 idle writes to both banks, with R2 lane merge
    for (int a = 0; a < 16; a++) begin
      logic [31:0] v;
      v = 32'hA5A5_0000 + 32'(a * 3);
      wr(5'(16 + a), v, 4'(a));
      mdl[a] = merge(mdl[a], v, 4'(a));
      rd(5'(16 + a), d);
      chk("R9 idle write / R2 coef lanes", d, mdl[a]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule